// File: doc/BRIEF.md
# Prioritized Interrupt Vector Address Generator

This block collects up to `NUM_EVT` interrupt events into two pending banks, a normal bank and a fast bank. A per-event type bit decides which bank an arriving event lands in. For each bank the block continuously produces a vector address that points into an entry table in memory, so a handler can jump straight to the routine of the winning event without scanning status registers.

The vector is a programmable base address plus an offset equal to (winning event number + 1) times the table entry size. Table slot 0, which sits at the base itself, is reserved and is returned when nothing qualifies. Within a bank the lowest event number wins. By default an event qualifies only if its enable bit is set. A per-bank raw-mode bit lets every pending event in that bank qualify, enabled or not. Pending bits are active-low: an arriving event drives its bit to 0, and software writes 1 to set it back to 1.

Registers are reached over a single-cycle port. A write takes effect at the clock edge. Read data is combinational from the address. `NUM_EVT` must be a multiple of 32 and at most 256. Each bit vector spans `NUM_EVT/32` consecutive 32-bit words, and word w holds events 32w to 32w+31.

Top module: `irq_vector_gen`

## Requirements
- R1: While a bank has at least one qualifying pending event, its vector output equals base + (n+1)*S. Here n is the lowest qualifying event number in that bank and S is the entry size in bytes.
- R2: The size field is control register (byte address 0x04) bits [1:0]. Codes 0, 1, 2 and 3 select S = 4, 8, 16 and 32 bytes.
- R3: When a bank has no qualifying pending event, its vector output equals the base register (byte address 0x00) exactly, and its request output is 0.
- R4: With raw mode off, an event qualifies only when its enable bit is 1. Enable words start at byte address 0x60, and a 1 means enabled.
- R5: Control bit 2 is raw mode for the normal bank and bit 3 is raw mode for the fast bank. With raw mode on, every pending event of that bank qualifies regardless of its enable bit.
- R6: An event input that is high at a clock edge clears its pending bit to 0 (pending) in the normal bank if its type bit is 0, or in the fast bank if its type bit is 1. Type words start at byte address 0x80. The vectors reflect the capture right after that edge.
- R7: The pending words read back as active-low bits, all 1 after reset. Normal-bank words start at byte address 0x20 and fast-bank words at 0x40. Writing 1 to a bit returns it to 1, and writing 0 leaves it unchanged.
- R8: If a capture and a write of 1 hit the same pending bit in the same cycle, the bit ends up 0 (pending).
- R9: Each bank's request output is 1 exactly when that bank has a qualifying pending event, under the same enable and raw-mode rules.
- R10: The base and control registers read back what was written. The normal and fast vectors can be read at byte addresses 0x08 and 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Event inputs, each captured when high at a clock edge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| nrm_req_o | output | 1 | Normal bank has a qualifying pending event |
| fst_req_o | output | 1 | Fast bank has a qualifying pending event |
| nrm_vec_o | output | AW | Normal bank vector address |
| fst_vec_o | output | AW | Fast bank vector address |

## Verification
Each event capture and each register write lands in a register at one clock edge, and both vectors and both requests follow combinationally from those registers. Every result is therefore due one edge after the stimulus. The driver pushes the model's expectation right after that edge, and the monitor compares it at the following falling edge. Read data depends only on the address and the registers, so register readbacks are checked within the same cycle, a moment after the address is applied, with no edge between.

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int NUM_EVT = 64,
  parameter int AW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               nrm_req_o,
  output logic               fst_req_o,
  output logic [AW-1:0]      nrm_vec_o,
  output logic [AW-1:0]      fst_vec_o
);
  localparam int NW = NUM_EVT / 32;
  localparam int IW = $clog2(NUM_EVT);

  logic [AW-1:0]      base_q;
  logic [1:0]         size_q;
  logic               raw_n_q, raw_f_q;
  logic [NUM_EVT-1:0] en_q, type_q, pnd_n_q, pnd_f_q;
  logic [NUM_EVT-1:0] cap_n, cap_f, rs_n, rs_f, qual_n, qual_f;
  logic [5:0]         widx;

  assign widx  = bus_addr[7:2];
  assign cap_n = evt_i & ~type_q;
  assign cap_f = evt_i & type_q;

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      rs_n[i] = bus_we && (widx == 6'(8 + i / 32))  && bus_wdata[i % 32];
      rs_f[i] = bus_we && (widx == 6'(16 + i / 32)) && bus_wdata[i % 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      size_q  <= '0;
      raw_n_q <= 1'b0;
      raw_f_q <= 1'b0;
      en_q    <= '0;
      type_q  <= '0;
      pnd_n_q <= '1;
      pnd_f_q <= '1;
    end else begin
      if (bus_we && widx == 6'd0) base_q <= AW'(bus_wdata);
      if (bus_we && widx == 6'd1) {raw_f_q, raw_n_q, size_q} <= bus_wdata[3:0];
      for (int i = 0; i < NUM_EVT; i++) begin
        if (bus_we && widx == 6'(24 + i / 32)) en_q[i]   <= bus_wdata[i % 32];
        if (bus_we && widx == 6'(32 + i / 32)) type_q[i] <= bus_wdata[i % 32];
      end
      pnd_n_q <= (pnd_n_q | rs_n) & ~cap_n;
      pnd_f_q <= (pnd_f_q | rs_f) & ~cap_f;
    end
  end

  assign qual_n = ~pnd_n_q & (raw_n_q ? {NUM_EVT{1'b1}} : en_q);
  assign qual_f = ~pnd_f_q & (raw_f_q ? {NUM_EVT{1'b1}} : en_q);

  function automatic logic [IW:0] first_set(input logic [NUM_EVT-1:0] v);
    logic [IW:0] r;
    r = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  logic [IW:0]   win_n, win_f;
  logic [2:0]    shamt;
  logic [AW-1:0] off_n, off_f;

  assign win_n     = first_set(qual_n);
  assign win_f     = first_set(qual_f);
  assign shamt     = {1'b0, size_q} + 3'd2;
  assign off_n     = (AW'(win_n[IW-1:0]) + AW'(1)) << shamt;
  assign off_f     = (AW'(win_f[IW-1:0]) + AW'(1)) << shamt;
  assign nrm_req_o = win_n[IW];
  assign fst_req_o = win_f[IW];
  assign nrm_vec_o = win_n[IW] ? base_q + off_n : base_q;
  assign fst_vec_o = win_f[IW] ? base_q + off_f : base_q;

  always_comb begin
    bus_rdata = '0;
    case (widx)
      6'd0: bus_rdata = 32'(base_q);
      6'd1: bus_rdata = {28'd0, raw_f_q, raw_n_q, size_q};
      6'd2: bus_rdata = 32'(nrm_vec_o);
      6'd3: bus_rdata = 32'(fst_vec_o);
      default: ;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (widx == 6'(8 + w))  bus_rdata = pnd_n_q[w*32 +: 32];
      if (widx == 6'(16 + w)) bus_rdata = pnd_f_q[w*32 +: 32];
      if (widx == 6'(24 + w)) bus_rdata = en_q[w*32 +: 32];
      if (widx == 6'(32 + w)) bus_rdata = type_q[w*32 +: 32];
    end
  end

  AST_NRM_EMPTY_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !nrm_req_o |-> nrm_vec_o == base_q); // R3
  AST_FST_EMPTY_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !fst_req_o |-> fst_vec_o == base_q); // R3
  AST_NRM_REQ_OFF_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    nrm_req_o |-> nrm_vec_o != base_q); // R1
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (((nrm_vec_o - base_q) | (fst_vec_o - base_q)) & ((AW'(4) << size_q) - AW'(1))) == '0); // R2
  AST_NRM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pnd_n_q & $past(cap_n)) == '0); // R6
  AST_FST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (pnd_f_q & $past(cap_f)) == '0); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !bus_we && evt_i == '0) |=> ($stable(pnd_n_q) && $stable(pnd_f_q))); // R7
endmodule

// File: tb/irq_vector_gen_tb.sv
module irq_vector_gen_tb;
  localparam int N = 64;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [N-1:0] evt_i = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic nrm_req_o, fst_req_o;
  logic [31:0] nrm_vec_o, fst_vec_o;

  irq_vector_gen #(.NUM_EVT(N), .AW(32)) u_dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] vn, vf;
    logic rn, rf;
    string tag;
  } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R3 reset";

  logic [31:0] m_base = 0;
  logic [1:0] m_size = 0;
  logic m_rawn = 0, m_rawf = 0;
  logic [N-1:0] m_en = '0, m_type = '0, m_pn = '1, m_pf = '1;

  function automatic exp_t model(string t);
    exp_t e;
    logic [N-1:0] qn, qf;
    qn = ~m_pn & (m_rawn ? {N{1'b1}} : m_en);
    qf = ~m_pf & (m_rawf ? {N{1'b1}} : m_en);
    e.vn = m_base; e.vf = m_base; e.rn = 0; e.rf = 0; e.tag = t;
    for (int i = N - 1; i >= 0; i--) begin
      if (qn[i]) begin e.rn = 1; e.vn = m_base + (32'(i) + 1) * (32'd4 << m_size); end
      if (qf[i]) begin e.rf = 1; e.vf = m_base + (32'(i) + 1) * (32'd4 << m_size); end
    end
    return e;
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic cycle(logic we, logic [7:0] a, logic [31:0] d, logic [N-1:0] ev);
    logic [N-1:0] capn, capf, rn, rf;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; evt_i = ev;
    @(posedge clk);
    #0;
    capn = ev & ~m_type; capf = ev & m_type; rn = '0; rf = '0;
    if (we) begin
      case (a)
        8'h00: m_base = d;
        8'h04: {m_rawf, m_rawn, m_size} = d[3:0];
        8'h20: rn[31:0] = d;
        8'h24: rn[63:32] = d;
        8'h40: rf[31:0] = d;
        8'h44: rf[63:32] = d;
        8'h60: m_en[31:0] = d;
        8'h64: m_en[63:32] = d;
        8'h80: m_type[31:0] = d;
        8'h84: m_type[63:32] = d;
        default: ;
      endcase
    end
    m_pn = (m_pn | rn) & ~capn;
    m_pf = (m_pf | rf) & ~capf;
    q.push_back(model(tag));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); cycle(1, a, d, '0); endtask
  task automatic ev(logic [N-1:0] e); cycle(0, 8'h00, 0, e); endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string t);
    @(negedge clk);
    bus_we = 0; evt_i = '0; bus_addr = a;
    #1;
    check(t, bus_rdata, exp);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " normal vector (R1/R3)"}, nrm_vec_o, e.vn);
        check({e.tag, " fast vector (R1/R3)"}, fst_vec_o, e.vf);
        check({e.tag, " normal request (R9)"}, 32'(nrm_req_o), 32'(e.rn));
        check({e.tag, " fast request (R9)"}, 32'(fst_req_o), 32'(e.rf));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst_n = 1;
    ev('0);
    rd(8'h20, 32'hFFFF_FFFF, "R7 reset pending normal");
    rd(8'h44, 32'hFFFF_FFFF, "R7 reset pending fast");
    rd(8'h08, 32'h0, "R3 reset vector");

    tag = "R10 base";
    wr(8'h00, 32'h0000_1000);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_1000, "R10 base readback");
    tag = "R6 capture";
    ev(64'h20);
    rd(8'h20, ~32'h20, "R6 pending bit low");
    rd(8'h08, 32'h1018, "R10 R1 normal vector read");
    tag = "R1 lowest wins";
    ev(64'h4);
    rd(8'h08, 32'h100C, "R1 lowest number wins");
    tag = "R7 write zero";
    wr(8'h20, 32'h0);
    rd(8'h20, ~32'h24, "R7 write zero no effect");
    tag = "R7 restore";
    wr(8'h20, 32'h4);
    rd(8'h20, ~32'h20, "R7 write one restores");
    tag = "R2 size";
    for (int s = 1; s < 4; s++) begin
      wr(8'h04, 32'(s));
      rd(8'h08, 32'h1000 + 6 * (32'd4 << s), "R2 entry size");
    end
    rd(8'h04, 32'h3, "R10 control readback");
    tag = "R4 disabled";
    wr(8'h60, ~32'h20);
    rd(8'h08, 32'h1000, "R3 R4 disabled gives base");
    tag = "R5 raw normal";
    wr(8'h04, 32'h7);
    rd(8'h08, 32'h10C0, "R5 raw mode qualifies");
    wr(8'h04, 32'h3);
    wr(8'h60, 32'hFFFF_FFFF);
    tag = "R6 fast bank";
    wr(8'h84, 32'h100);
    ev(64'h1 << 40);
    rd(8'h44, ~32'h100, "R6 fast pending bit");
    rd(8'h24, 32'hFFFF_FFFF, "R6 normal bank untouched");
    rd(8'h0C, 32'h1000 + 41 * 32, "R1 fast vector read");
    tag = "R8 capture wins";
    cycle(1, 8'h44, 32'h100, 64'h1 << 40);
    rd(8'h44, ~32'h100, "R8 capture beats restore");
    tag = "R1 top event";
    wr(8'h20, 32'hFFFF_FFFF);
    ev(64'h1 << 63);
    rd(8'h08, 32'h1000 + 64 * 32, "R1 highest event number");

    tag = "R1/R2/R4/R5 random";
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] e;
      e = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      case ($urandom % 8)
        0, 1, 2: ev(e);
        3: cycle(1, 8'h04, $urandom, e);
        4: cycle(1, 8'h20 + 8'(4 * ($urandom % 2)), $urandom, e);
        5: cycle(1, 8'h40 + 8'(4 * ($urandom % 2)), $urandom, e);
        6: cycle(1, 8'h60 + 8'(4 * ($urandom % 2)), $urandom | $urandom, e);
        default: cycle(1, 8'h80 + 8'(4 * ($urandom % 2)), $urandom, e);
      endcase
      if (k % 25 == 0) begin
        rd(8'h20, m_pn[31:0], "R6/R7 random pending normal");
        rd(8'h44, m_pf[63:32], "R6/R7 random pending fast");
      end
    end
    tag = "R3 empty";
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    ev('0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule